// File: doc/BRIEF.md
# Per-Lane SPI Input/Output Retiming Stage

This block sits between the SPI data pads and the shift register of a SPI controller. On the receive side it takes four raw data lanes from the pads. It can optionally exchange neighbouring lanes. It then gives each logical lane its own sampling source and delay depth before the value reaches the shifter. On the transmit side each of the four shifter output lanes either goes straight to its pad or is re-registered on the falling edge of the module clock.

The block is used to compensate for board and pad skew without changing the shifter. Each receive lane chooses one of four settings: bypass, rising-edge capture, falling-edge capture, or capture on the SPI clock. A per-lane count sets the depth of the delay. Every delay chain shifts on each edge of its own clock, whatever the lane's current setting. A newly chosen setting therefore delivers history that is already valid.

Top module: `spi_lane_retime`

## Requirements
- R1: With receive mode code 0 (bypass), `din_o[i]` follows the logical input lane combinationally, in the same cycle and with no register.
- R2: With receive mode code 1 and count 0, `din_o[i]` equals the logical input lane as captured at the most recent rising edge of `clk_i`.
- R3: With receive mode code 2 and count 0, `din_o[i]` equals the logical input lane as captured at the most recent falling edge of `clk_i`.
- R4: With receive mode code 3 and count 0, `din_o[i]` equals the logical input lane as captured at the most recent rising edge of `sck_i`.
- R5: For modes 1 to 3, a count value k (field `in_cnt_i[2*i +: 2]`) makes `din_o[i]` the value captured k+1 edges of the selected clock earlier, which gives 1 to 4 edges.
- R6: With transmit mode bit `out_mode_i[i]` = 0, `pad_dout_o[i]` equals `shift_dout_i[i]` combinationally.
- R7: With `out_mode_i[i]` = 1, `pad_dout_o[i]` holds the value of `shift_dout_i[i]` captured at the most recent falling edge of `clk_i`.
- R8: With `swap_en_i` = 1, logical lanes 0,1,2,3 are fed from pad lanes 1,0,3,2. The exchange is applied before any delay register, so chains store the lanes as they were mapped at capture time.
- R9: While `rst_ni` is low, every delay and retiming register is 0. Any lane in a registered mode therefore outputs 0.
- R10: Every delay chain shifts continuously whatever the selected mode and count. After a change of mode or count, the output in that same cycle already shows the value that the new setting implies, with no glitch value in between.
- R11: The receive mode field of lane i is `in_mode_i[2*i +: 2]`, and the encoding is 0 bypass, 1 rising edge, 2 falling edge, 3 SPI clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock for rising- and falling-edge capture |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI clock used by receive mode 3 |
| in_mode_i | input | 8 | Receive mode per lane, 2 bits each, lane i at [2i+1:2i] |
| in_cnt_i | input | 8 | Receive delay count per lane, 2 bits each, lane i at [2i+1:2i] |
| out_mode_i | input | 4 | Transmit retime enable per lane |
| swap_en_i | input | 1 | Exchange pad lanes pairwise (0<->1, 2<->3) |
| pad_din_i | input | 4 | Raw receive lanes from the pads |
| din_o | output | 4 | Retimed logical receive lanes to the shifter |
| shift_dout_i | input | 4 | Transmit lanes from the shifter |
| pad_dout_o | output | 4 | Retimed transmit lanes to the pads |

## Verification
Bypass results (receive mode 0 and transmit mode 0) are due in the same cycle as the input change. Rising-edge lanes are due after k+1 rising edges of `clk_i`, falling-edge lanes and transmit retiming after the matching falling edge, and SPI-clock lanes after k+1 rising edges of `sck_i`. The bench changes inputs 1 ns after a rising edge and samples 4 ns after it. That point lies past the falling edge and at least 1 ns away from every `sck_i` edge. A bench model keeps its own histories of the mapped lanes at each of the three capture edges, and reads the expected value out of the depth that the requirement names. Checks made in the cycle of a configuration change are tagged for the no-stale-data rule.

// File: rtl/spi_lane_pkg.sv
`timescale 1ns/1ps
package spi_lane_pkg;

  typedef enum logic [1:0] {
    IN_BYPASS = 2'd0,
    IN_RISE   = 2'd1,
    IN_FALL   = 2'd2,
    IN_SCK    = 2'd3
  } in_mode_e;

  // partner lane under pairwise exchange
  function automatic int pair_of(input int idx);
    return idx ^ 1;
  endfunction

endpackage

// File: rtl/lane_swap.sv
`timescale 1ns/1ps
module lane_swap #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] phys_i,
  input  logic             swap_i,
  output logic [LANES-1:0] log_o
);
  import spi_lane_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int PARTNER = pair_of(i);
    assign log_o[i] = swap_i ? phys_i[PARTNER] : phys_i[i];
  end

endmodule

// File: rtl/in_lane_delay.sv
`timescale 1ns/1ps
module in_lane_delay
  import spi_lane_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             lane_i,
  input  in_mode_e         mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             lane_o
);
  localparam int DEPTH = 1 << CNT_W;
  localparam logic [CNT_W:0] WARM_MAX = (CNT_W+1)'(DEPTH);
  localparam logic [CNT_W:0] WARM_TWO = (CNT_W+1)'(2);

  logic [DEPTH-1:0] rise_q, fall_q, sck_q;

  // all chains run regardless of selection: a new setting sees valid history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= {rise_q[DEPTH-2:0], lane_i};
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= {fall_q[DEPTH-2:0], lane_i};
  end

  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= '0;
    else         sck_q <= {sck_q[DEPTH-2:0], lane_i};
  end

  always_comb begin
    lane_o = lane_i;
    case (mode_i)
      IN_RISE: lane_o = rise_q[cnt_i];
      IN_FALL: lane_o = fall_q[cnt_i];
      IN_SCK:  lane_o = sck_q[cnt_i];
      default: lane_o = lane_i;
    endcase
  end

  // edges seen since reset, for assertion history guards
  logic [CNT_W:0] warm_q;
  logic           fwarm_q, swarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                warm_q <= '0;
    else if (warm_q != WARM_MAX) warm_q <= warm_q + 1'b1;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fwarm_q <= 1'b0;
    else         fwarm_q <= 1'b1;
  end

  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni) swarm_q <= 1'b0;
    else         swarm_q <= 1'b1;
  end

  p_rise_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == IN_RISE && cnt_i == '0 && warm_q != '0) |-> lane_o == $past(lane_i));

  p_rise_two_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == IN_RISE && cnt_i == CNT_W'(1) && warm_q >= WARM_TWO)
      |-> lane_o == $past(lane_i, 2));

  p_fall_one_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (mode_i == IN_FALL && cnt_i == '0 && fwarm_q) |-> lane_o == $past(lane_i));

  p_sck_one_r4: assert property (@(posedge sck_i) disable iff (!rst_ni)
    (mode_i == IN_SCK && cnt_i == '0 && swarm_q) |-> lane_o == $past(lane_i));

endmodule

// File: rtl/out_lane_retime.sv
`timescale 1ns/1ps
module out_lane_retime (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic mode_i,
  output logic bit_o
);
  logic neg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= bit_i;
  end

  assign bit_o = mode_i ? neg_q : bit_i;

  logic warm_q;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= 1'b0;
    else         warm_q <= 1'b1;
  end

  p_out_neg_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (warm_q && mode_i) |-> bit_o == $past(bit_i));

endmodule

// File: rtl/spi_lane_retime.sv
`timescale 1ns/1ps
module spi_lane_retime
  import spi_lane_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sck_i,
  input  logic [2*LANES-1:0]     in_mode_i,
  input  logic [CNT_W*LANES-1:0] in_cnt_i,
  input  logic [LANES-1:0]       out_mode_i,
  input  logic                   swap_en_i,
  input  logic [LANES-1:0]       pad_din_i,
  output logic [LANES-1:0]       din_o,
  input  logic [LANES-1:0]       shift_dout_i,
  output logic [LANES-1:0]       pad_dout_o
);

  logic [LANES-1:0] log_din;

  lane_swap #(.LANES(LANES)) u_swap (
    .phys_i (pad_din_i),
    .swap_i (swap_en_i),
    .log_o  (log_din)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    in_lane_delay #(.CNT_W(CNT_W)) u_in (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sck_i  (sck_i),
      .lane_i (log_din[i]),
      .mode_i (in_mode_e'(in_mode_i[2*i +: 2])),
      .cnt_i  (in_cnt_i[CNT_W*i +: CNT_W]),
      .lane_o (din_o[i])
    );

    out_lane_retime u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bit_i  (shift_dout_i[i]),
      .mode_i (out_mode_i[i]),
      .bit_o  (pad_dout_o[i])
    );
  end

  p_pair_swap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_en_i && in_mode_i[1:0] == 2'd0) |-> din_o[0] == pad_din_i[1]);

endmodule

// File: tb/spi_lane_retime_test.sv
`timescale 1ns/1ps
module spi_lane_retime_test;

  logic       clk = 1'b0;
  logic       sck = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_mode = '0;
  logic [7:0] in_cnt = '0;
  logic [3:0] out_mode = '0;
  logic       swap = 1'b0;
  logic [3:0] pad = '0;
  logic [3:0] shf = '0;
  logic [3:0] din, pdo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cfg_chg = 1'b0;

  always #2.5 clk = ~clk;
  initial begin
    #3;
    forever #10 sck = ~sck;
  end

  spi_lane_retime uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck),
    .in_mode_i(in_mode), .in_cnt_i(in_cnt), .out_mode_i(out_mode),
    .swap_en_i(swap), .pad_din_i(pad), .din_o(din),
    .shift_dout_i(shf), .pad_dout_o(pdo)
  );

  // R8 mapping: logical i <- pad i^1 when swapped
  function automatic logic [3:0] mapped(input logic [3:0] p, input logic sw);
    return sw ? {p[2], p[3], p[0], p[1]} : p;
  endfunction

  // model histories, index 0 = most recent capture
  logic [3:0] rise_h [4];
  logic [3:0] fall_h [4];
  logic [3:0] sck_h  [4];
  logic [3:0] out_h;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int j = 0; j < 4; j++) rise_h[j] = '0;
    else begin
      for (int j = 3; j > 0; j--) rise_h[j] = rise_h[j-1];
      rise_h[0] = mapped(pad, swap);
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < 4; j++) fall_h[j] = '0;
      out_h = '0;
    end else begin
      for (int j = 3; j > 0; j--) fall_h[j] = fall_h[j-1];
      fall_h[0] = mapped(pad, swap);
      out_h = shf;
    end
  end

  always @(posedge sck or negedge rst_n) begin
    if (!rst_n) for (int j = 0; j < 4; j++) sck_h[j] = '0;
    else begin
      for (int j = 3; j > 0; j--) sck_h[j] = sck_h[j-1];
      sck_h[0] = mapped(pad, swap);
    end
  end

  function automatic logic exp_din(input int i);
    int k;
    k = int'(in_cnt[2*i +: 2]);
    case (in_mode[2*i +: 2])
      2'd0:    return mapped(pad, swap)[i];
      2'd1:    return rise_h[k][i];
      2'd2:    return fall_h[k][i];
      default: return sck_h[k][i];
    endcase
  endfunction

  function automatic logic exp_dout(input int i);
    return out_mode[i] ? out_h[i] : shf[i];
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string tag;
    for (int i = 0; i < 4; i++) begin
      case (in_mode[2*i +: 2])
        2'd0:    tag = "R1 R11";
        2'd1:    tag = (in_cnt[2*i +: 2] == 0) ? "R2" : "R2 R5";
        2'd2:    tag = (in_cnt[2*i +: 2] == 0) ? "R3" : "R3 R5";
        default: tag = (in_cnt[2*i +: 2] == 0) ? "R4" : "R4 R5";
      endcase
      if (swap)    tag = {tag, " R8"};
      if (cfg_chg) tag = {tag, " R10"};
      chk($sformatf("%s din lane %0d", tag, i), {3'b0, din[i]}, {3'b0, exp_din(i)});
      chk($sformatf("%s dout lane %0d", out_mode[i] ? "R7" : "R6", i),
          {3'b0, pdo[i]}, {3'b0, exp_dout(i)});
    end
  endtask

  // drive 1 ns after rising edge, check 4 ns after it
  task automatic step(input logic [3:0] p, input logic [3:0] s);
    @(posedge clk);
    #1;
    pad = p;
    shf = s;
    #3;
    check_all();
    cfg_chg = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    // R9: registered modes output 0 while in reset
    in_mode  = 8'b01_11_10_01;
    in_cnt   = 8'b00_01_10_11;
    out_mode = 4'hF;
    pad = 4'hF;
    shf = 4'hF;
    repeat (6) @(posedge clk);
    #4;
    chk("R9 din in reset", din, 4'h0);
    chk("R9 dout in reset", pdo, 4'h0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 directed: pad lane 0 appears on logical lane 1
    in_mode = '0; out_mode = '0; swap = 1'b1;
    step(4'b0001, 4'h0);
    chk("R8 swap pad0->log1", din, 4'b0010);
    step(4'b0100, 4'h0);
    chk("R8 swap pad2->log3", din, 4'b1000);
    swap = 1'b0;

    // R10 directed: rising mode depth switch shows older history at once
    in_mode = 8'b01_01_01_01; in_cnt = '0;
    step(4'h1, 4'h0);
    step(4'h2, 4'h0);
    step(4'h4, 4'h0);
    step(4'h8, 4'h0);
    @(posedge clk);
    #1 in_cnt = 8'hFF; pad = 4'h0;
    #3 chk("R10 R5 depth switch count 3", din, 4'h1);
    in_cnt = 8'h00;
    #0 chk("R10 R2 depth switch count 0", din, 4'h8);

    // random mix, new configuration every 16 cycles
    for (int c = 0; c < 1600; c++) begin
      if (c % 16 == 0) begin
        @(posedge clk);
        #1;
        in_mode  = 8'($urandom);
        in_cnt   = 8'($urandom);
        out_mode = 4'($urandom);
        swap     = 1'($urandom);
        pad      = 4'($urandom);
        shf      = 4'($urandom);
        cfg_chg  = 1'b1;
        #3;
        check_all();
        cfg_chg = 1'b0;
      end else begin
        step(4'($urandom), 4'($urandom));
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule